// File: doc/BRIEF.md
# Descriptor-Chained Frame Writer

This block stores captured frames in memory by walking a chain of frame descriptors. Each descriptor is three 32-bit words in memory, read in this order: the buffer address, the control word, and the address of the next descriptor. The channel fetches one descriptor over a read port that holds each request until it is acknowledged. It then writes each incoming pixel word to consecutive memory words starting at the buffer address. The word that carries the end-of-frame marker completes the frame.

When a frame completes, the channel can write the descriptor's control word back with its done bit set. It then raises a sticky done flag and, if the descriptor asks for it, a one-cycle interrupt pulse. After that it either follows the link to the next descriptor or stops. Software works through a small register port: a descriptor pointer, a channel control word, write-only enable and disable strobes, a status word, and a configuration bit that switches chain mode on.

Pixel words that arrive while the channel is stopped, or while it is still reading a descriptor, are accepted and discarded, and a sticky overrun flag records that. While a data word or a write-back waits for the write port, the pixel input is stalled and nothing is lost.

Top module: `frame_chain_dma`

## Requirements
- R1: After reset the channel is stopped, every register (pointer at address 0, control at 1, status at 4, configuration at 5) reads zero, and neither memory port requests.
- R2: A descriptor at pointer P is read as three words at byte addresses P, P+4 and P+8, in that order. Each read request holds its address until it is acknowledged.
- R3: A write of 1 to bit 0 of address 2 starts the channel only when three conditions hold: configuration bit 0 (chain mode) is set, control bit 0 (fetch) is set, and the channel is stopped. Otherwise the write is ignored.
- R4: Pixel word n of a frame is written to buffer address + 4n. The word accepted with the end-of-frame marker is the frame's last word. While the write port withholds its acknowledge, the pixel input is stalled.
- R5: If bit 1 of the descriptor's control word is set, the control word with bit 3 (done) set is written to P+4 after the frame's last data word.
- R6: Every completed frame sets status bit 1. A frame whose control word has bit 2 set also gives a frame_irq pulse one cycle long.
- R7: After a frame, a descriptor with control bit 0 set and a nonzero next address makes that address the new pointer and starts its fetch. Otherwise the channel stops by itself and status bit 0 (active) clears.
- R8: A pixel word offered while the channel is stopped or still fetching is accepted and dropped with no memory write, and status bit 2 (overrun) is set.
- R9: A write of 1 to bit 0 of address 3 lets the frame in progress finish, including its write-back, and then stops the channel without following the link.
- R10: Writing 1 to status bit 1 or bit 2 clears that flag. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel word taken this cycle |
| pix_data | input | 32 | Pixel word |
| pix_eof | input | 1 | Marks the last word of a frame |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read completes, rd_data valid |
| rd_data | input | 32 | Memory read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Write accepted |
| frame_irq | output | 1 | One-cycle pulse for a frame that asks for an interrupt |

## Verification
The hardest case to reach from the ports is a pixel arriving during a descriptor fetch. The window lasts only a few cycles and has no visible marker. The bench reaches it by offering a pixel in the very cycle after the enable write, while read acknowledges are withheld on a fixed stall pattern, so the fetch is certain to be under way. A second hard case is a disable request that lands in the middle of a frame whose descriptor links to itself. Any extra descriptor read then shows up as an unexpected read against the bench's queue of expected reads.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CAPT  = 3'd2,
    ST_WBACK = 3'd3,
    ST_FIN   = 3'd4
  } fcd_state_e;

  // register port addresses
  localparam logic [2:0] RA_PTR  = 3'd0;
  localparam logic [2:0] RA_CTRL = 3'd1;
  localparam logic [2:0] RA_ENA  = 3'd2;
  localparam logic [2:0] RA_DIS  = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;
  localparam logic [2:0] RA_CFG  = 3'd5;

  // control word bit positions (shared with the descriptor in memory)
  localparam int CB_FETCH = 0;
  localparam int CB_WB    = 1;
  localparam int CB_IE    = 2;
  localparam int CB_DONE  = 3;

  // status bit positions
  localparam int SB_ACTIVE = 0;
  localparam int SB_DONE   = 1;
  localparam int SB_OVR    = 2;

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          chan_active,
  input  logic          eng_ptr_load,
  input  logic [AW-1:0] eng_ptr_val,
  input  logic          eng_done_set,
  input  logic          eng_ovr_set,
  output logic [AW-1:0] ptr_q,
  output logic [DW-1:0] ctrl_q,
  output logic          chain_en,
  output logic          done_q,
  output logic          ovr_q,
  output logic          start_req,
  output logic          stop_req
);

  logic [AW-1:0] ptr_d;
  logic [DW-1:0] ctrl_d;
  logic          cfg_q, cfg_d;
  logic          done_d, ovr_d;
  logic          ptr_en, ctrl_en, cfg_en, flag_en;
  logic          wr_ptr, wr_ctrl, wr_stat, wr_cfg;

  assign wr_ptr  = reg_we && (reg_addr == RA_PTR);
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);
  assign wr_cfg  = reg_we && (reg_addr == RA_CFG);

  assign start_req = reg_we && (reg_addr == RA_ENA) && reg_wdata[0];
  assign stop_req  = reg_we && (reg_addr == RA_DIS) && reg_wdata[0];
  assign chain_en  = cfg_q;

  always_comb begin
    ptr_d   = ptr_q;
    ctrl_d  = ctrl_q;
    cfg_d   = cfg_q;
    done_d  = done_q;
    ovr_d   = ovr_q;
    ptr_en  = wr_ptr | eng_ptr_load;
    ctrl_en = wr_ctrl;
    cfg_en  = wr_cfg;
    flag_en = wr_stat | eng_done_set | eng_ovr_set;
    if (wr_ptr)       ptr_d = AW'(reg_wdata);
    if (eng_ptr_load) ptr_d = eng_ptr_val;
    if (wr_ctrl)      ctrl_d = reg_wdata;
    if (wr_cfg)       cfg_d = reg_wdata[0];
    if (wr_stat && reg_wdata[SB_DONE]) done_d = 1'b0;
    if (wr_stat && reg_wdata[SB_OVR])  ovr_d  = 1'b0;
    if (eng_done_set) done_d = 1'b1;
    if (eng_ovr_set)  ovr_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ctrl_q <= '0;
      cfg_q  <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (cfg_en)  cfg_q  <= cfg_d;
      if (flag_en) begin
        done_q <= done_d;
        ovr_q  <= ovr_d;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PTR:  reg_rdata = DW'(ptr_q);
      RA_CTRL: reg_rdata = ctrl_q;
      RA_STAT: begin
        reg_rdata[SB_ACTIVE] = chan_active;
        reg_rdata[SB_DONE]   = done_q;
        reg_rdata[SB_OVR]    = ovr_q;
      end
      RA_CFG:  reg_rdata[0] = cfg_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fcd_engine.sv
module fcd_engine
  import fcd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chain_en,
  input  logic [DW-1:0] ctrl_q,
  input  logic [AW-1:0] ptr_q,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_eof,
  output logic          pix_ready,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          frame_irq,
  output logic          ptr_load,
  output logic [AW-1:0] ptr_val,
  output logic          done_set,
  output logic          ovr_set,
  output logic          active
);

  localparam int WORD_SH = 2;
  localparam logic [AW-1:0] CTRL_OFS = AW'(1 << WORD_SH);

  fcd_state_e       state_q, state_d;
  logic [1:0]       idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    buf_q, next_q;
  logic [DW-1:0]    dctl_q;
  logic             stop_q, stop_d;
  logic             buf_en, dctl_en, next_en;
  logic             last_word;

  assign active    = (state_q != ST_IDLE);
  assign last_word = (idx_q == 2'd2);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    buf_en    = 1'b0;
    dctl_en   = 1'b0;
    next_en   = 1'b0;
    pix_ready = 1'b0;
    rd_req    = 1'b0;
    rd_addr   = ptr_q + AW'({idx_q, {WORD_SH{1'b0}}});
    wr_req    = 1'b0;
    wr_addr   = buf_q + AW'({cnt_q, {WORD_SH{1'b0}}});
    wr_data   = pix_data;
    frame_irq = 1'b0;
    ptr_load  = 1'b0;
    ptr_val   = next_q;
    done_set  = 1'b0;
    ovr_set   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        pix_ready = 1'b1;
        ovr_set   = pix_valid;
        if (start_req && chain_en && ctrl_q[CB_FETCH]) begin
          state_d = ST_FETCH;
          idx_d   = 2'd0;
        end
      end
      ST_FETCH: begin
        pix_ready = 1'b1;
        ovr_set   = pix_valid;
        rd_req    = 1'b1;
        if (rd_ack) begin
          buf_en  = (idx_q == 2'd0);
          dctl_en = (idx_q == 2'd1);
          next_en = last_word;
          if (last_word) begin
            state_d = ST_CAPT;
            cnt_d   = '0;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      ST_CAPT: begin
        if (stop_q && (cnt_q == '0)) begin
          state_d = ST_IDLE;
        end else begin
          wr_req    = pix_valid;
          pix_ready = wr_ack;
          if (pix_valid && wr_ack) begin
            cnt_d = cnt_q + 1'b1;
            if (pix_eof) state_d = dctl_q[CB_WB] ? ST_WBACK : ST_FIN;
          end
        end
      end
      ST_WBACK: begin
        wr_req  = 1'b1;
        wr_addr = ptr_q + CTRL_OFS;
        wr_data = dctl_q | (DW'(1) << CB_DONE);
        if (wr_ack) state_d = ST_FIN;
      end
      ST_FIN: begin
        done_set  = 1'b1;
        frame_irq = dctl_q[CB_IE];
        if (!stop_q && dctl_q[CB_FETCH] && (next_q != '0)) begin
          ptr_load = 1'b1;
          state_d  = ST_FETCH;
          idx_d    = 2'd0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    stop_d = stop_q | (stop_req && active);
    if (state_d == ST_IDLE) stop_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
      buf_q   <= '0;
      dctl_q  <= '0;
      next_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
      if (buf_en)  buf_q  <= AW'(rd_data);
      if (dctl_en) dctl_q <= rd_data;
      if (next_en) next_q <= AW'(rd_data);
    end
  end

endmodule

// File: rtl/frame_chain_dma.sv
module frame_chain_dma
  import fcd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_eof,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          frame_irq
);

  logic          chan_active;
  logic          ptr_load, done_set, ovr_set;
  logic [AW-1:0] ptr_val, ptr_q;
  logic [DW-1:0] ctrl_q;
  logic          chain_en, done_flag, ovr_flag;
  logic          start_req, stop_req;

  fcd_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .chan_active  (chan_active),
    .eng_ptr_load (ptr_load),
    .eng_ptr_val  (ptr_val),
    .eng_done_set (done_set),
    .eng_ovr_set  (ovr_set),
    .ptr_q        (ptr_q),
    .ctrl_q       (ctrl_q),
    .chain_en     (chain_en),
    .done_q       (done_flag),
    .ovr_q        (ovr_flag),
    .start_req    (start_req),
    .stop_req     (stop_req)
  );

  fcd_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .chain_en  (chain_en),
    .ctrl_q    (ctrl_q),
    .ptr_q     (ptr_q),
    .start_req (start_req),
    .stop_req  (stop_req),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_eof   (pix_eof),
    .pix_ready (pix_ready),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .frame_irq (frame_irq),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .done_set  (done_set),
    .ovr_set   (ovr_set),
    .active    (chan_active)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic          frame_irq,
  input logic          chan_active,
  input logic          done_flag,
  input logic          ovr_flag
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> (!rd_req && !wr_req));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  p_irq_sets_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> done_flag);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !wr_req) |=> ovr_flag);

endmodule

bind frame_chain_dma fcd_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_ack      (rd_ack),
  .rd_addr     (rd_addr),
  .wr_req      (wr_req),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .frame_irq   (frame_irq),
  .chan_active (chan_active),
  .done_flag   (done_flag),
  .ovr_flag    (ovr_flag)
);

// File: tb/frame_chain_dma_test.sv
`timescale 1ns/1ps
module frame_chain_dma_test;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pix_valid, pix_ready, pix_eof;
  logic [31:0] pix_data;
  logic        rd_req, rd_ack, wr_req, wr_ack, frame_irq;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;

  logic [31:0] mem [0:255];
  int          cyc;
  int          checks, errors, irq_seen;
  bit          finished;
  logic [31:0] exp_rd[$];
  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];

  frame_chain_dma uut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pix_eof(pix_eof),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .frame_irq(frame_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model with a fixed stall pattern on both ports
  assign rd_ack  = rd_req && ((cyc % 3) != 2);
  assign wr_ack  = wr_req && ((cyc % 4) != 3);
  assign rd_data = mem[rd_addr[9:2]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: every handshake compared one ns before the edge
  always @(negedge clk) begin
    #9;
    if (rst_n) begin
      if (rd_req && rd_ack) begin
        if (exp_rd.size() == 0) chk("R2 unexpected read", rd_addr, 32'hFFFF_FFFF);
        else chk("R2 read address", rd_addr, exp_rd.pop_front());
      end
      if (wr_req && wr_ack) begin
        if (exp_wa.size() == 0) chk("R4/R8 unexpected write", wr_addr, 32'hFFFF_FFFF);
        else begin
          chk("R4/R5 write address", wr_addr, exp_wa.pop_front());
          chk("R4/R5 write data", wr_data, exp_wd.pop_front());
        end
        mem[wr_addr[9:2]] = wr_data;
      end
      if (frame_irq) irq_seen++;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] nx);
    mem[p[9:2]]       = b;
    mem[p[9:2] + 8'd1] = c;
    mem[p[9:2] + 8'd2] = nx;
  endtask

  task automatic expect_fetch(input logic [31:0] p);
    exp_rd.push_back(p);
    exp_rd.push_back(p + 4);
    exp_rd.push_back(p + 8);
  endtask

  task automatic expect_data(input logic [31:0] b, input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      exp_wa.push_back(b + 32'(4 * i));
      exp_wd.push_back(base + 32'(i));
    end
  endtask

  task automatic send(input logic [31:0] base, input int n, input bit end_frame);
    for (int i = 0; i < n; i++) begin
      bit acc;
      @(negedge clk);
      pix_valid = 1'b1;
      pix_data  = base + 32'(i);
      pix_eof   = end_frame && (i == n - 1);
      forever begin
        #1 acc = pix_ready;
        @(posedge clk);
        if (acc) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    pix_valid = 1'b0;
    pix_eof   = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    cyc = 0; checks = 0; errors = 0; irq_seen = 0; finished = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 1'b0; pix_data = '0; pix_eof = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(3'd4, v); chk("R1 status", v, 32'h0);
    rd_reg(3'd0, v); chk("R1 pointer", v, 32'h0);
    rd_reg(3'd1, v); chk("R1 control", v, 32'h0);
    rd_reg(3'd5, v); chk("R1 config", v, 32'h0);
    chk("R1 no requests", {31'b0, rd_req | wr_req}, 32'h0);

    // R3 enable ignored without chain mode, then without fetch bit
    put_desc(32'h100, 32'h200, 32'h7, 32'h140);
    put_desc(32'h140, 32'h300, 32'h2, 32'h0);
    wr_reg(3'd0, 32'h100);
    wr_reg(3'd1, 32'h9);
    wr_reg(3'd2, 32'h1);
    idle(5);
    rd_reg(3'd4, v); chk("R3 no chain mode", v, 32'h0);
    wr_reg(3'd5, 32'h1);
    wr_reg(3'd1, 32'h8);
    wr_reg(3'd2, 32'h1);
    idle(5);
    rd_reg(3'd4, v); chk("R3 no fetch bit", v, 32'h0);
    wr_reg(3'd1, 32'h9);

    // R2 R4 R5 R6 R7 two-descriptor chain
    expect_fetch(32'h100);
    wr_reg(3'd2, 32'h1);
    idle(15);
    rd_reg(3'd4, v); chk("R3 started", v, 32'h1);
    expect_data(32'h200, 32'hA000, 4);
    exp_wa.push_back(32'h104); exp_wd.push_back(32'hF);
    expect_fetch(32'h140);
    send(32'hA000, 4, 1'b1);
    idle(15);
    rd_reg(3'd0, v); chk("R7 pointer follows link", v, 32'h140);
    rd_reg(3'd4, v); chk("R6 done while active", v, 32'h3);
    chk("R6 irq once", 32'(irq_seen), 32'd1);
    expect_data(32'h300, 32'hB000, 3);
    exp_wa.push_back(32'h144); exp_wd.push_back(32'hA);
    send(32'hB000, 3, 1'b1);
    idle(10);
    rd_reg(3'd4, v); chk("R7 stops at end of chain", v, 32'h2);
    chk("R6 no irq without enable bit", 32'(irq_seen), 32'd1);
    chk("R5 write-back in memory", mem[8'h41], 32'hF);

    // R10 clear done
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, v); chk("R10 clear done", v, 32'h0);

    // R8 drop while stopped
    send(32'hC000, 2, 1'b1);
    idle(3);
    rd_reg(3'd4, v); chk("R8 overrun when stopped", v, 32'h4);
    wr_reg(3'd4, 32'h4);
    rd_reg(3'd4, v); chk("R10 clear overrun", v, 32'h0);

    // R8 drop during fetch, then a frame with no write-back
    put_desc(32'h180, 32'h380, 32'h1, 32'h0);
    wr_reg(3'd0, 32'h180);
    expect_fetch(32'h180);
    wr_reg(3'd2, 32'h1);
    send(32'hD000, 1, 1'b1);
    idle(15);
    rd_reg(3'd4, v); chk("R8 overrun during fetch", v, 32'h5);
    expect_data(32'h380, 32'hE000, 2);
    send(32'hE000, 2, 1'b1);
    idle(10);
    rd_reg(3'd4, v); chk("R7 zero link stops", v, 32'h6);
    wr_reg(3'd4, 32'h6);

    // R9 disable mid-frame on a self-linked descriptor, R3 restart ignored
    put_desc(32'h1C0, 32'h3C0, 32'h3, 32'h1C0);
    wr_reg(3'd0, 32'h1C0);
    expect_fetch(32'h1C0);
    wr_reg(3'd2, 32'h1);
    idle(15);
    expect_data(32'h3C0, 32'hF000, 4);
    exp_wa.push_back(32'h1C4); exp_wd.push_back(32'hB);
    send(32'hF000, 2, 1'b0);
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd3, 32'h1);
    rd_reg(3'd4, v); chk("R9 still active mid-frame", v, 32'h1);
    send(32'hF002, 2, 1'b1);
    idle(15);
    rd_reg(3'd4, v); chk("R9 stopped after frame", v, 32'h2);
    chk("R6 irq count final", 32'(irq_seen), 32'd1);

    chk("R2 all reads seen", 32'(exp_rd.size()), 32'd0);
    chk("R4 all writes seen", 32'(exp_wa.size()), 32'd0);
    summary();
  end

endmodule